// File: doc/BRIEF.md
# External Memory Chip-Select Controller

This block connects a single-request internal port to an asynchronous external SRAM or ROM bus. A requester presents an address, write data, a read/write flag and a space flag that selects program or data space. The block then runs one external access. Address and chip selects are set up first. An active-low read or write strobe follows, stretched by a programmable number of wait states. A final hold cycle ends the access. Read data and a one-cycle done pulse are returned to the requester.

Four active-low chip selects are produced. Select 0 serves program space and select 1 serves data space. Each of the remaining selects asserts when the access address, ANDed with its mask, equals its base and the region is enabled. The data bus is split into an output word, an input word and an output enable, so the pad ring can build the tri-state pin. A second enable covers the address, strobe and chip-select pins. It is always on during an access. When the bus is idle it follows a drive bit, which either keeps the bus held or releases it to high impedance.

Top module: `emc_ctrl`

## Requirements
- R1: `req_ready` is high only when no access is in progress. A request is taken at a clock edge where `req_valid` and `req_ready` are both high. A request held on `req_valid` while busy is stalled and then serviced with the field values present when it is taken.
- R2: Address and chip selects reach their access values one cycle before a strobe falls. They keep those values for the cycle after the strobe rises. The read strobe and the write strobe are never low together.
- R3: A strobe stays low for W+1 clock cycles. W is `cfg_wait`, sampled when the request is taken. Values above 30 act as 30.
- R4: During a read, `ext_rd_n` is low and `ext_dq_oe` stays low. `rsp_rdata` takes the value of `ext_dq_i` at the clock edge where `ext_rd_n` rises, and it is valid while `rsp_done` is high.
- R5: During a write, `ext_wr_n` is low. `ext_dq_oe` is high and `ext_dq_o` carries the request's write data from setup through hold, so the device can latch it when the strobe rises.
- R6: `rsp_done` is a single-cycle pulse in the hold cycle, once per access. `req_ready` is high again in the following cycle.
- R7: Chip select bit 0 is low for program-space accesses (`req_prog`=1). Bit 1 is low for data-space accesses (`req_prog`=0). Exactly one of the two is low during a strobe.
- R8: Chip select bit 2+i is low for an access when `cfg_rgn_en[i]` is 1 and (address AND mask i) equals base i, regardless of space. Base i and mask i occupy bits [i*AW +: AW] of the flat config ports.
- R9: `ext_ctl_oe` is high throughout an access. When the bus is idle it equals `cfg_drive`, delayed by one register.
- R10: While reset is high: `req_ready`=1, all chip selects high, both strobes high, `rsp_done`=0, `ext_dq_oe`=0, `ext_ctl_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait | input | 5 | Wait states per access (31 acts as 30) |
| cfg_drive | input | 1 | 1 keeps address, strobes and selects driven while idle |
| cfg_rgn_en | input | 2 | Enable per address region (selects 2 and 3) |
| cfg_rgn_base | input | 40 | Region bases, AW bits each |
| cfg_rgn_mask | input | 40 | Region masks, AW bits each |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 20 | Access address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 write, 0 read |
| req_prog | input | 1 | 1 program space, 0 data space |
| rsp_rdata | output | 16 | Read data |
| rsp_done | output | 1 | Access complete pulse |
| ext_addr | output | 20 | External address |
| ext_dq_o | output | 16 | Data driven to pins |
| ext_dq_i | input | 16 | Data from pins |
| ext_dq_oe | output | 1 | Data pin output enable |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_cs_n | output | 4 | Chip selects, active low |
| ext_ctl_oe | output | 1 | Output enable for address, strobes and selects |

## Verification
The completion of one access and the arrival of the next request can fall in the same cycle. The hold cycle raises the done pulse while a stalled request still sits on the port with new fields. The bench provokes this by keeping `req_valid` high right after a write is taken and swapping in a second write's address and data. Correct handling is judged three ways: exactly one done pulse per access, `req_ready` low during the stall, and both locations reading back their own data afterwards.

// File: rtl/emc_pkg.sv
`timescale 1ns/1ps
package emc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } emc_state_e;
endpackage

// File: rtl/emc_region_match.sv
`timescale 1ns/1ps
module emc_region_match #(
  parameter int AW = 20
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  input  logic          en,
  output logic          hit
);
  assign hit = en && ((addr & mask) == base);
endmodule

// File: rtl/emc_wait_ctr.sv
`timescale 1ns/1ps
module emc_wait_ctr #(
  parameter int WAIT_W   = 5,
  parameter int WAIT_MAX = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              dec,
  output logic              zero
);
  localparam logic [WAIT_W-1:0] LIM = WAIT_W'(WAIT_MAX);

  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= (load_val > LIM) ? LIM : load_val;
    else if (dec && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R3: the wait count never exceeds the supported maximum
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst) cnt <= LIM);
endmodule

// File: rtl/emc_ctrl.sv
`timescale 1ns/1ps
module emc_ctrl
  import emc_pkg::*;
#(
  parameter  int AW       = 20,
  parameter  int DW       = 16,
  parameter  int WAIT_MAX = 30,
  parameter  int WAIT_W   = 5,
  parameter  int NRGN     = 2,
  localparam int NCS      = 2 + NRGN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic               cfg_drive,
  input  logic [NRGN-1:0]    cfg_rgn_en,
  input  logic [NRGN*AW-1:0] cfg_rgn_base,
  input  logic [NRGN*AW-1:0] cfg_rgn_mask,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  input  logic               req_write,
  input  logic               req_prog,
  output logic [DW-1:0]      rsp_rdata,
  output logic               rsp_done,
  output logic [AW-1:0]      ext_addr,
  output logic [DW-1:0]      ext_dq_o,
  input  logic [DW-1:0]      ext_dq_i,
  output logic               ext_dq_oe,
  output logic               ext_rd_n,
  output logic               ext_wr_n,
  output logic [NCS-1:0]     ext_cs_n,
  output logic               ext_ctl_oe
);
  emc_state_e     st, st_n;
  logic           accept, we_q, we_nx, wait_zero;
  logic [NRGN-1:0] rgn_hit;
  logic [NCS-1:0] cs_hit;

  for (genvar g = 0; g < NRGN; g++) begin : g_rgn
    emc_region_match #(.AW(AW)) u_match (
      .addr (req_addr),
      .base (cfg_rgn_base[g*AW +: AW]),
      .mask (cfg_rgn_mask[g*AW +: AW]),
      .en   (cfg_rgn_en[g]),
      .hit  (rgn_hit[g])
    );
  end

  assign cs_hit    = {rgn_hit, ~req_prog, req_prog};
  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign we_nx     = accept ? req_write : we_q;

  emc_wait_ctr #(.WAIT_W(WAIT_W), .WAIT_MAX(WAIT_MAX)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (cfg_wait),
    .dec      (st == ST_STROBE),
    .zero     (wait_zero)
  );

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE:   if (req_valid) st_n = ST_SETUP;
      ST_SETUP:  st_n = ST_STROBE;
      ST_STROBE: if (wait_zero) st_n = ST_HOLD;
      ST_HOLD:   st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      we_q       <= 1'b0;
      ext_addr   <= '0;
      ext_dq_o   <= '0;
      ext_cs_n   <= '1;
      ext_rd_n   <= 1'b1;
      ext_wr_n   <= 1'b1;
      ext_dq_oe  <= 1'b0;
      ext_ctl_oe <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      st <= st_n;
      if (accept) begin
        we_q     <= req_write;
        ext_addr <= req_addr;
        ext_dq_o <= req_wdata;
      end
      if (accept)
        ext_cs_n <= ~cs_hit;
      else if (st_n == ST_IDLE)
        ext_cs_n <= '1;
      ext_rd_n   <= !(st_n == ST_STROBE && !we_nx);
      ext_wr_n   <= !(st_n == ST_STROBE && we_nx);
      ext_dq_oe  <= (st_n != ST_IDLE) && we_nx;
      ext_ctl_oe <= (st_n != ST_IDLE) || cfg_drive;
      rsp_done   <= (st_n == ST_HOLD);
      if (st == ST_STROBE && st_n == ST_HOLD && !we_q)
        rsp_rdata <= ext_dq_i;
    end
  end

  // R2: strobes are mutually exclusive
  a_r2_no_dual_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n));
  // R2: selects already set up when a strobe falls
  a_r2_setup: assert property (@(posedge clk) disable iff (rst)
    ($fell(ext_rd_n) || $fell(ext_wr_n)) |-> ($stable(ext_cs_n) && $stable(ext_addr) && ext_cs_n != '1));
  // R2: selects and address held across the strobe's rising edge
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    ($rose(ext_rd_n) || $rose(ext_wr_n)) |-> ($stable(ext_cs_n) && $stable(ext_addr) && ext_cs_n != '1));
  // R4: data pins released while reading
  a_r4_read_hiz: assert property (@(posedge clk) disable iff (rst)
    !ext_rd_n |-> !ext_dq_oe);
  // R5: data pins driven while writing
  a_r5_write_drv: assert property (@(posedge clk) disable iff (rst)
    !ext_wr_n |-> ext_dq_oe);
  // R6: done is one cycle wide
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  // R7: exactly one space select during a strobe
  a_r7_one_space: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_wr_n) |-> ($countones(~ext_cs_n[1:0]) == 1));
  // R9: control pins driven during a strobe
  a_r9_ctl_driven: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_wr_n) |-> ext_ctl_oe);
endmodule

// File: tb/sim_emc_ctrl.sv
`timescale 1ns/1ps
module sim_emc_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cfg_wait = '0;
  logic        cfg_drive = 1'b0;
  logic [1:0]  cfg_rgn_en = '0;
  logic [39:0] cfg_rgn_base = '0;
  logic [39:0] cfg_rgn_mask = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_prog = 1'b0;
  logic [15:0] rsp_rdata;
  logic        rsp_done;
  logic [19:0] ext_addr;
  logic [15:0] ext_dq_o;
  logic [15:0] ext_dq_i;
  logic        ext_dq_oe, ext_rd_n, ext_wr_n, ext_ctl_oe;
  logic [3:0]  ext_cs_n;

  always #10 clk = ~clk;

  emc_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_wait(cfg_wait), .cfg_drive(cfg_drive),
    .cfg_rgn_en(cfg_rgn_en), .cfg_rgn_base(cfg_rgn_base), .cfg_rgn_mask(cfg_rgn_mask),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_prog(req_prog),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .ext_addr(ext_addr),
    .ext_dq_o(ext_dq_o), .ext_dq_i(ext_dq_i), .ext_dq_oe(ext_dq_oe),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_cs_n(ext_cs_n),
    .ext_ctl_oe(ext_ctl_oe)
  );

  // external memory model: data valid only while read strobe is low
  logic [15:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  assign ext_dq_i = (!ext_rd_n) ? mem[ext_addr[7:0]] : 16'hDEAD;
  always @(posedge ext_wr_n) if (!rst) mem[ext_addr[7:0]] <= ext_dq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor, sampled at the falling clock edge
  int stb_total = 0, done_total = 0;
  int v_setup = 0, v_hold = 0, v_rdoe = 0, v_wroe = 0, v_both = 0, v_ctl = 0;
  logic [3:0] cs_seen = 4'hF;
  logic       p_stb = 1'b1;
  logic [3:0] p_cs = 4'hF;
  logic [19:0] p_addr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      logic stb;
      stb = ext_rd_n & ext_wr_n;
      if (!stb) begin
        stb_total++;
        cs_seen = ext_cs_n;
        if (!ext_ctl_oe) v_ctl++;
      end
      if (!ext_rd_n && !ext_wr_n) v_both++;
      if (!ext_rd_n && ext_dq_oe) v_rdoe++;
      if (!ext_wr_n && !ext_dq_oe) v_wroe++;
      if (p_stb && !stb && (p_cs != ext_cs_n || p_cs == 4'hF || p_addr != ext_addr)) v_setup++;
      if (!p_stb && stb && (p_cs != ext_cs_n || ext_cs_n == 4'hF || p_addr != ext_addr || !ext_dq_oe == !ext_wr_n && 1'b0)) v_hold++;
      if (rsp_done) done_total++;
      p_stb  = stb;
      p_cs   = ext_cs_n;
      p_addr = ext_addr;
    end
  end

  task automatic wait_done(input string req, output logic [15:0] q);
    bit got = 0;
    q = '0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rsp_done) begin got = 1; q = rsp_rdata; break; end
    end
    check({req, " done seen"}, got, 1'b1);
    check({req, " ready low in hold"}, req_ready, 1'b0);
    @(negedge clk);
    check({req, " ready back"}, req_ready, 1'b1);
  endtask

  // one full access starting at a falling edge while idle
  task automatic access(input logic wr, input logic prog, input logic [19:0] a,
                        input logic [15:0] d, output logic [15:0] q,
                        output int stbs, output logic [3:0] cs);
    int s0, d0;
    s0 = stb_total; d0 = done_total;
    req_valid = 1'b1; req_write = wr; req_prog = prog; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R6", q);
    stbs = stb_total - s0;
    cs = cs_seen;
    check("R6 one done per access", done_total - d0, 1);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    check("R10 ready", req_ready, 1'b1);
    check("R10 cs_n", ext_cs_n, 4'hF);
    check("R10 rd_n", ext_rd_n, 1'b1);
    check("R10 wr_n", ext_wr_n, 1'b1);
    check("R10 done", rsp_done, 1'b0);
    check("R10 dq_oe", ext_dq_oe, 1'b0);
    check("R10 ctl_oe", ext_ctl_oe, 1'b0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_prog_space;
    logic [15:0] q; int n; logic [3:0] cs;
    cfg_wait = 5'd0;
    access(1'b1, 1'b1, 20'h00012, 16'hA5A5, q, n, cs);
    check("R3 wait0 write strobe cycles", n, 1);
    check("R7 program select", cs, 4'b1110);
    access(1'b0, 1'b1, 20'h00012, 16'h0, q, n, cs);
    check("R4 program read data", q, 16'hA5A5);
    check("R3 wait0 read strobe cycles", n, 1);
  endtask

  task automatic t_data_space;
    logic [15:0] q; int n; logic [3:0] cs;
    cfg_wait = 5'd3;
    access(1'b1, 1'b0, 20'h00034, 16'h1234, q, n, cs);
    check("R3 wait3 strobe cycles", n, 4);
    check("R7 data select", cs, 4'b1101);
    cfg_wait = 5'd0;   // count sampled at acceptance of the read below
    access(1'b0, 1'b0, 20'h00034, 16'h0, q, n, cs);
    check("R4 data read data", q, 16'h1234);
    check("R3 count resampled", n, 1);
  endtask

  task automatic t_wait_max;
    logic [15:0] q; int n; logic [3:0] cs;
    cfg_wait = 5'd30;
    access(1'b0, 1'b0, 20'h00034, 16'h0, q, n, cs);
    check("R3 wait30 strobe cycles", n, 31);
    check("R4 long read data", q, 16'h1234);
    cfg_wait = 5'd31;
    access(1'b1, 1'b0, 20'h00035, 16'h7E7E, q, n, cs);
    check("R3 wait31 clamps to 30", n, 31);
    cfg_wait = 5'd0;
  endtask

  task automatic t_region;
    logic [15:0] q; int n; logic [3:0] cs;
    cfg_rgn_en = 2'b01;
    cfg_rgn_base = {20'h00080, 20'h00040};
    cfg_rgn_mask = {20'hFFFF0, 20'hFFFC0};
    access(1'b0, 1'b0, 20'h00045, 16'h0, q, n, cs);
    check("R8 region0 data space", cs, 4'b1001);
    access(1'b0, 1'b1, 20'h00047, 16'h0, q, n, cs);
    check("R8 region0 program space", cs, 4'b1010);
    access(1'b0, 1'b0, 20'h00085, 16'h0, q, n, cs);
    check("R8 region1 disabled", cs, 4'b1101);
    cfg_rgn_en = 2'b11;
    access(1'b0, 1'b0, 20'h00085, 16'h0, q, n, cs);
    check("R8 region1 enabled", cs, 4'b0101);
    cfg_rgn_en = 2'b00;
  endtask

  task automatic t_drive;
    logic [15:0] q; int n; logic [3:0] cs;
    cfg_drive = 1'b0;
    @(negedge clk);
    check("R9 idle released", ext_ctl_oe, 1'b0);
    cfg_drive = 1'b1;
    @(negedge clk);
    check("R9 idle held", ext_ctl_oe, 1'b1);
    access(1'b0, 1'b0, 20'h00034, 16'h0, q, n, cs);
    check("R9 held after access", ext_ctl_oe, 1'b1);
    cfg_drive = 1'b0;
    @(negedge clk);
    check("R9 released again", ext_ctl_oe, 1'b0);
  endtask

  task automatic t_stall;
    logic [15:0] q; int n, d0; logic [3:0] cs;
    d0 = done_total;
    cfg_wait = 5'd2;
    req_valid = 1'b1; req_write = 1'b1; req_prog = 1'b0;
    req_addr = 20'h00010; req_wdata = 16'h1111;
    @(posedge clk);
    @(negedge clk);
    check("R1 ready low while busy", req_ready, 1'b0);
    req_addr = 20'h00020; req_wdata = 16'h2222;
    wait_done("R1 first", q);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R1 second", q);
    check("R6 two done pulses", done_total - d0, 2);
    access(1'b0, 1'b0, 20'h00010, 16'h0, q, n, cs);
    check("R1 first write kept its data", q, 16'h1111);
    access(1'b0, 1'b0, 20'h00020, 16'h0, q, n, cs);
    check("R1 stalled write serviced", q, 16'h2222);
    cfg_wait = 5'd0;
  endtask

  task automatic finish_run;
    check("R2 setup before strobe", v_setup, 0);
    check("R2 hold after strobe", v_hold, 0);
    check("R2 dual strobe", v_both, 0);
    check("R4 data released on read", v_rdoe, 0);
    check("R5 data driven on write", v_wroe, 0);
    check("R9 driven during strobe", v_ctl, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_prog_space();
    t_data_space();
    t_wait_max();
    t_region();
    t_drive();
    t_stall();
    finish_run();
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule